// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit resolves conditional branches for a processor pipeline with 24-bit instructions. The inputs are a decoded branch instruction, the values of its two source registers and the address of the instruction. The unit decides whether the branch is taken and computes the address fetch continues from. It does not read the register file. The caller supplies both operands already read, and the unit never looks at the register-select field of the instruction.

It handles three groups of branches. The first compares one register against zero and uses a 12-bit displacement. The second compares one register against a small constant that it picks from a fixed 16-entry signed or unsigned table, and uses an 8-bit displacement. The third compares two registers, either arithmetically or as mask and single-bit tests, and also uses an 8-bit displacement. The result is registered and appears one clock after the request, marked by a valid strobe for the fetch stage. Any encoding outside these groups is flagged as illegal and falls through.

Field positions used below: `op = insn[3:0]`, `n = insn[5:4]`, `m = insn[7:6]`, `t = insn[7:4]`, `r = insn[15:12]`, `imm8 = insn[23:16]`, `imm12 = insn[23:12]`. Operand A is `opS`, operand B is `opT`. The 8-bit displacement branches are all of the op=7 group, and the op=6 group with n=2 or n=3.

Top module: `brResolve`

## Requirements
- R1: When op=6 and n=1, the unit compares opS with zero. m=0 branches on equal, m=1 on not-equal, m=2 on signed less-than and m=3 on signed greater-or-equal. The taken target is pc + 4 + sign-extended imm12.
- R2: When op=6 and n=2, the unit compares opS with an entry from the signed table {-1, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256}, indexed by r. m selects the condition with the same coding as in R1.
- R3: When op=6 and n=3 with m=2, the unit branches if opS is unsigned-less-than an entry of the table {32768, 65536, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256}, indexed by r. With m=3 it branches on unsigned greater-or-equal against the same entry.
- R4: Every branch with an 8-bit displacement targets pc + 4 + sign-extended imm8. Any branch that is not taken gives pc + 3.
- R5: When op=7, r[3] inverts the condition and r[2:0] picks the test. r[2:0]=1 tests equality, r[2:0]=2 tests signed less-than and r[2:0]=3 tests unsigned less-than. Inverting these gives not-equal, signed greater-or-equal and unsigned greater-or-equal.
- R6: When op=7, r[2:0]=0 branches if (opS AND opT) is zero, and the inverted form branches if it is non-zero. r[2:0]=4 branches if (opS AND opT) equals opT, and the inverted form branches if it does not.
- R7: When op=7 and r[2:0]=5, the unit tests bit opT[4:0] of opS. It branches if that bit is clear, and the inverted form branches if it is set.
- R8: When op=7 and r[2:0] is 6 or 7, the unit tests the opS bit at index {r[0], t}. It branches if that bit is clear, and the inverted form branches if it is set.
- R9: Each of these encodings sets illegal, forces taken low and gives pc + 3 as the next address: op other than 6 or 7, op=6 with n=0, and op=6 with n=3 and m below 2.
- R10: outValid is high exactly one cycle after inValid. taken, nextPc and illegal take their new values in that same cycle and keep them while inValid stays low.
- R11: While in reset, outValid, taken, illegal and nextPc are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A branch request is present this cycle |
| insn | input | 24 | Branch instruction word |
| opS | input | DATA_W | First register operand |
| opT | input | DATA_W | Second register operand |
| pc | input | ADDR_W | Address of the branch instruction |
| outValid | output | 1 | Registered result is valid |
| taken | output | 1 | Branch taken |
| nextPc | output | ADDR_W | Address to fetch next |
| illegal | output | 1 | Encoding not recognised |

## Verification
Nearly all of the state that matters is the decoded control word, and it lasts for only one cycle. A wrong source select, compare kind or inversion therefore shows up as a wrong taken bit on the very next outValid. When the taken bit flips, nextPc also moves between the target and pc + 3. A wrong displacement width shows up at once as a target that is off by a sign-extension amount. The bench checks each condition on both sides of its boundary, and each table at entries whose values are not simply their own index. It checks that the registered result stays frozen during idle cycles, so a capture enable that is stuck on or stuck off shows up within one cycle.

// File: rtl/brResolve_pkg.sv
`timescale 1ns/1ps
package brResolve_pkg;

  localparam int INSN_W = 24;
  localparam int CONST_W = 32;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_STAB,
    SRC_UTAB,
    SRC_REG
  } srcSel_e;

  typedef enum logic [2:0] {
    K_EQ,
    K_LT,
    K_LTU,
    K_NONE,
    K_ALL,
    K_BIT
  } cmpKind_e;

  typedef struct packed {
    logic     capture;
    logic     illegal;
    srcSel_e  src;
    cmpKind_e kind;
    logic     invert;
    logic     wideOff;
    logic     bitFromReg;
  } ctrl_t;

  function automatic logic [CONST_W-1:0] signedConst(input logic [3:0] idx);
    case (idx)
      4'd0:    signedConst = '1;
      4'd9:    signedConst = CONST_W'(10);
      4'd10:   signedConst = CONST_W'(12);
      4'd11:   signedConst = CONST_W'(16);
      4'd12:   signedConst = CONST_W'(32);
      4'd13:   signedConst = CONST_W'(64);
      4'd14:   signedConst = CONST_W'(128);
      4'd15:   signedConst = CONST_W'(256);
      default: signedConst = CONST_W'(idx);
    endcase
  endfunction

  function automatic logic [CONST_W-1:0] unsignedConst(input logic [3:0] idx);
    case (idx)
      4'd0:    unsignedConst = CONST_W'(32768);
      4'd1:    unsignedConst = CONST_W'(65536);
      default: unsignedConst = signedConst(idx);
    endcase
  endfunction

endpackage

// File: rtl/brResolve_ctrl.sv
`timescale 1ns/1ps
module brResolve_ctrl
  import brResolve_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [INSN_W-1:0] insn,
  output ctrl_t             ctrl,
  output logic              outValid
);

  logic [3:0] opField;
  logic [1:0] nField;
  logic [1:0] mField;
  logic [3:0] rField;

  assign opField = insn[3:0];
  assign nField  = insn[5:4];
  assign mField  = insn[7:6];
  assign rField  = insn[15:12];

  always_comb begin
    ctrl            = '0;
    ctrl.capture    = inValid;
    ctrl.illegal    = 1'b1;
    ctrl.src        = SRC_ZERO;
    ctrl.kind       = K_EQ;
    if (opField == 4'd6) begin
      case (nField)
        2'd1: begin
          ctrl.illegal = 1'b0;
          ctrl.src     = SRC_ZERO;
          ctrl.kind    = mField[1] ? K_LT : K_EQ;
          ctrl.invert  = mField[0];
          ctrl.wideOff = 1'b1;
        end
        2'd2: begin
          ctrl.illegal = 1'b0;
          ctrl.src     = SRC_STAB;
          ctrl.kind    = mField[1] ? K_LT : K_EQ;
          ctrl.invert  = mField[0];
        end
        2'd3: begin
          if (mField[1]) begin
            ctrl.illegal = 1'b0;
            ctrl.src     = SRC_UTAB;
            ctrl.kind    = K_LTU;
            ctrl.invert  = mField[0];
          end
        end
        default: ctrl.illegal = 1'b1;
      endcase
    end else if (opField == 4'd7) begin
      ctrl.illegal = 1'b0;
      ctrl.src     = SRC_REG;
      ctrl.invert  = rField[3];
      case (rField[2:0])
        3'd0: ctrl.kind = K_NONE;
        3'd1: ctrl.kind = K_EQ;
        3'd2: ctrl.kind = K_LT;
        3'd3: ctrl.kind = K_LTU;
        3'd4: ctrl.kind = K_ALL;
        3'd5: begin
          ctrl.kind       = K_BIT;
          ctrl.bitFromReg = 1'b1;
        end
        default: ctrl.kind = K_BIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/brResolve_dp.sv
`timescale 1ns/1ps
module brResolve_dp
  import brResolve_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [3:0]        tabIdx,
  input  logic [4:0]        bitImm,
  input  logic [7:0]        imm8,
  input  logic [11:0]       imm12,
  input  logic [DATA_W-1:0] opS,
  input  logic [DATA_W-1:0] opT,
  input  logic [ADDR_W-1:0] pc,
  output logic              taken,
  output logic [ADDR_W-1:0] nextPc,
  output logic              illegal
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] andV;
  logic [IDX_W-1:0]  bitIdx;
  logic              rawCond;
  logic              takenD;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] fallThru;
  logic [ADDR_W-1:0] nextD;

  always_comb begin
    case (ctrl.src)
      SRC_STAB: opB = DATA_W'(signed'(signedConst(tabIdx)));
      SRC_UTAB: opB = DATA_W'(unsignedConst(tabIdx));
      SRC_REG:  opB = opT;
      default:  opB = '0;
    endcase
  end

  assign andV   = opS & opT;
  assign bitIdx = ctrl.bitFromReg ? opT[IDX_W-1:0] : IDX_W'(bitImm);

  always_comb begin
    case (ctrl.kind)
      K_EQ:    rawCond = (opS == opB);
      K_LT:    rawCond = ($signed(opS) < $signed(opB));
      K_LTU:   rawCond = (opS < opB);
      K_NONE:  rawCond = (andV == '0);
      K_ALL:   rawCond = (andV == opT);
      K_BIT:   rawCond = ~opS[bitIdx];
      default: rawCond = 1'b0;
    endcase
  end

  assign takenD   = (rawCond ^ ctrl.invert) & ~ctrl.illegal;
  assign offset   = ctrl.wideOff ? {{(ADDR_W-12){imm12[11]}}, imm12}
                                 : {{(ADDR_W-8){imm8[7]}}, imm8};
  assign target   = pc + ADDR_W'(4) + offset;
  assign fallThru = pc + ADDR_W'(3);
  assign nextD    = takenD ? target : fallThru;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      taken   <= 1'b0;
      nextPc  <= '0;
      illegal <= 1'b0;
    end else if (ctrl.capture) begin
      taken   <= takenD;
      nextPc  <= nextD;
      illegal <= ctrl.illegal;
    end
  end

endmodule

// File: rtl/brResolve.sv
`timescale 1ns/1ps
module brResolve
  import brResolve_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [23:0]       insn,
  input  logic [DATA_W-1:0] opS,
  input  logic [DATA_W-1:0] opT,
  input  logic [ADDR_W-1:0] pc,
  output logic              outValid,
  output logic              taken,
  output logic [ADDR_W-1:0] nextPc,
  output logic              illegal
);

  ctrl_t ctrl;

  brResolve_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .insn     (insn),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  brResolve_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .tabIdx  (insn[15:12]),
    .bitImm  ({insn[12], insn[7:4]}),
    .imm8    (insn[23:16]),
    .imm12   (insn[23:12]),
    .opS     (opS),
    .opT     (opT),
    .pc      (pc),
    .taken   (taken),
    .nextPc  (nextPc),
    .illegal (illegal)
  );

endmodule

// File: rtl/brResolve_chk.sv
`timescale 1ns/1ps
module brResolve_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [23:0]       insn,
  input logic [DATA_W-1:0] opS,
  input logic [DATA_W-1:0] opT,
  input logic [ADDR_W-1:0] pc,
  input logic              outValid,
  input logic              taken,
  input logic [ADDR_W-1:0] nextPc,
  input logic              illegal
);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(taken) && $stable(nextPc) && $stable(illegal)));

  a_r9_illegal_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !taken);

  a_r4_fall_through: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && insn[3:0] != 4'd6 && insn[3:0] != 4'd7)
      |=> (illegal && nextPc == $past(pc) + ADDR_W'(3)));

  a_r5_equal_test: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && insn[3:0] == 4'd7 && insn[15:12] == 4'd1)
      |=> (taken == ($past(opS) == $past(opT))));

  a_r11_reset_idle: assert property (@(posedge clk)
    !rstN |-> (!outValid && !taken && !illegal));

endmodule

bind brResolve brResolve_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .insn     (insn),
  .opS      (opS),
  .opT      (opT),
  .pc       (pc),
  .outValid (outValid),
  .taken    (taken),
  .nextPc   (nextPc),
  .illegal  (illegal)
);

// File: tb/brResolve_test.sv
`timescale 1ns/1ps
module brResolve_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] insn = '0;
  logic [31:0] opS = '0;
  logic [31:0] opT = '0;
  logic [31:0] pc = '0;
  logic        outValid;
  logic        taken;
  logic [31:0] nextPc;
  logic        illegal;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  localparam logic [31:0] PC0 = 32'h0000_1000;

  always #2 clk = ~clk;

  brResolve uut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .insn     (insn),
    .opS      (opS),
    .opT      (opT),
    .pc       (pc),
    .outValid (outValid),
    .taken    (taken),
    .nextPc   (nextPc),
    .illegal  (illegal)
  );

  function automatic logic [23:0] encZero(input logic [1:0] m, input logic [11:0] off);
    return {off, 4'h0, m, 2'd1, 4'h6};
  endfunction

  function automatic logic [23:0] encImm(input logic [1:0] n, input logic [1:0] m,
                                         input logic [3:0] r, input logic [7:0] off);
    return {off, r, 4'h0, m, n, 4'h6};
  endfunction

  function automatic logic [23:0] encReg(input logic [3:0] r, input logic [3:0] t,
                                         input logic [7:0] off);
    return {off, r, 4'h0, t, 4'h7};
  endfunction

  task automatic runOne(input string tag, input logic [23:0] i, input logic [31:0] s,
                        input logic [31:0] t, input logic [31:0] p, input logic expT,
                        input logic [31:0] expN, input logic expI);
    @(negedge clk);
    inValid = 1'b1; insn = i; opS = s; opT = t; pc = p;
    @(negedge clk);
    inValid = 1'b0;
    testsRun++;
    if (outValid !== 1'b1 || taken !== expT || nextPc !== expN || illegal !== expI) begin
      testsFailed++;
      $display("FAIL %s: got v=%0b taken=%0b next=%h ill=%0b, expected v=1 taken=%0b next=%h ill=%0b",
               tag, outValid, taken, nextPc, illegal, expT, expN, expI);
    end
  endtask

  task automatic testReset();
    testsRun++;
    if (outValid !== 1'b0 || taken !== 1'b0 || illegal !== 1'b0 || nextPc !== 32'h0) begin
      testsFailed++;
      $display("FAIL R11: got v=%0b taken=%0b next=%h ill=%0b, expected all zero",
               outValid, taken, nextPc, illegal);
    end
  endtask

  task automatic testZeroCompare();
    runOne("R1 eq zero taken",  encZero(2'd0, 12'h010), 32'd0, 32'd0, PC0, 1'b1, 32'h1014, 1'b0);
    runOne("R1 eq zero not",    encZero(2'd0, 12'h010), 32'd5, 32'd0, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R1 ne zero taken",  encZero(2'd1, 12'h010), 32'd5, 32'd0, PC0, 1'b1, 32'h1014, 1'b0);
    runOne("R1 lt neg offset",  encZero(2'd2, 12'hFF0), 32'hFFFF_FFFF, 32'd0, PC0, 1'b1, 32'h0FF4, 1'b0);
    runOne("R1 ge zero taken",  encZero(2'd3, 12'h020), 32'd0, 32'd0, PC0, 1'b1, 32'h1024, 1'b0);
    runOne("R1 ge min not",     encZero(2'd3, 12'h020), 32'h8000_0000, 32'd0, PC0, 1'b0, 32'h1003, 1'b0);
  endtask

  task automatic testSignedTable();
    runOne("R2 eq entry0 -1",   encImm(2'd2, 2'd0, 4'd0, 8'h08), 32'hFFFF_FFFF, 32'd0, PC0, 1'b1, 32'h100C, 1'b0);
    runOne("R2 lt 10 taken",    encImm(2'd2, 2'd2, 4'd9, 8'h08), 32'd9, 32'd0, PC0, 1'b1, 32'h100C, 1'b0);
    runOne("R2 lt 10 not",      encImm(2'd2, 2'd2, 4'd9, 8'h08), 32'd10, 32'd0, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R2 ge 256 not",     encImm(2'd2, 2'd3, 4'd15, 8'h08), 32'hFFFF_FFFB, 32'd0, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R2 ge 256 taken",   encImm(2'd2, 2'd3, 4'd15, 8'h08), 32'd256, 32'd0, PC0, 1'b1, 32'h100C, 1'b0);
    runOne("R2 ne 1 not",       encImm(2'd2, 2'd1, 4'd1, 8'h08), 32'd1, 32'd0, PC0, 1'b0, 32'h1003, 1'b0);
  endtask

  task automatic testUnsignedTable();
    runOne("R3 ltu 32768 taken", encImm(2'd3, 2'd2, 4'd0, 8'h10), 32'd32767, 32'd0, PC0, 1'b1, 32'h1014, 1'b0);
    runOne("R3 ltu 32768 not",   encImm(2'd3, 2'd2, 4'd0, 8'h10), 32'hFFFF_FFFF, 32'd0, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R3 geu 65536 taken", encImm(2'd3, 2'd3, 4'd1, 8'h10), 32'd65536, 32'd0, PC0, 1'b1, 32'h1014, 1'b0);
    runOne("R3 geu 2 not",       encImm(2'd3, 2'd3, 4'd2, 8'h10), 32'd1, 32'd0, PC0, 1'b0, 32'h1003, 1'b0);
  endtask

  task automatic testOffsets();
    runOne("R4 imm8 -128",      encReg(4'd1, 4'd0, 8'h80), 32'd7, 32'd7, PC0, 1'b1, 32'h0F84, 1'b0);
    runOne("R4 imm8 +127",      encReg(4'd1, 4'd0, 8'h7F), 32'd7, 32'd7, PC0, 1'b1, 32'h1083, 1'b0);
    runOne("R4 imm8 fallthru",  encReg(4'd1, 4'd0, 8'h7F), 32'd7, 32'd8, PC0, 1'b0, 32'h1003, 1'b0);
  endtask

  task automatic testRegCompare();
    runOne("R5 eq taken",       encReg(4'd1, 4'd0, 8'h04), 32'd3, 32'd3, PC0, 1'b1, 32'h1008, 1'b0);
    runOne("R5 ne on equal",    encReg(4'd9, 4'd0, 8'h04), 32'd3, 32'd3, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R5 lt signed",      encReg(4'd2, 4'd0, 8'h04), 32'hFFFF_FFFF, 32'd1, PC0, 1'b1, 32'h1008, 1'b0);
    runOne("R5 ge signed not",  encReg(4'd10, 4'd0, 8'h04), 32'hFFFF_FFFF, 32'd1, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R5 ltu not",        encReg(4'd3, 4'd0, 8'h04), 32'hFFFF_FFFF, 32'd1, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R5 geu taken",      encReg(4'd11, 4'd0, 8'h04), 32'hFFFF_FFFF, 32'd1, PC0, 1'b1, 32'h1008, 1'b0);
  endtask

  task automatic testMasks();
    runOne("R6 none taken",     encReg(4'd0, 4'd0, 8'h04), 32'h0000_00F0, 32'h0000_000F, PC0, 1'b1, 32'h1008, 1'b0);
    runOne("R6 any not",        encReg(4'd8, 4'd0, 8'h04), 32'h0000_00F0, 32'h0000_000F, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R6 all taken",      encReg(4'd4, 4'd0, 8'h04), 32'h0000_00FF, 32'h0000_000F, PC0, 1'b1, 32'h1008, 1'b0);
    runOne("R6 all not",        encReg(4'd4, 4'd0, 8'h04), 32'h0000_00F7, 32'h0000_000F, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R6 notall taken",   encReg(4'd12, 4'd0, 8'h04), 32'h0000_00F7, 32'h0000_000F, PC0, 1'b1, 32'h1008, 1'b0);
  endtask

  task automatic testBitReg();
    runOne("R7 clear on set31", encReg(4'd5, 4'd0, 8'h04), 32'h8000_0000, 32'd31, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R7 set bit31",      encReg(4'd13, 4'd0, 8'h04), 32'h8000_0000, 32'd31, PC0, 1'b1, 32'h1008, 1'b0);
    runOne("R7 index masked",   encReg(4'd13, 4'd0, 8'h04), 32'h0000_0001, 32'h0000_0020, PC0, 1'b1, 32'h1008, 1'b0);
  endtask

  task automatic testBitImm();
    runOne("R8 clear bit3 not", encReg(4'd6, 4'd3, 8'h04), 32'h0000_0008, 32'd0, PC0, 1'b0, 32'h1003, 1'b0);
    runOne("R8 set bit3",       encReg(4'd14, 4'd3, 8'h04), 32'h0000_0008, 32'd0, PC0, 1'b1, 32'h1008, 1'b0);
    runOne("R8 set bit20",      encReg(4'd15, 4'd4, 8'h04), 32'h0010_0000, 32'd0, PC0, 1'b1, 32'h1008, 1'b0);
    runOne("R8 clear bit20 not",encReg(4'd7, 4'd4, 8'h04), 32'h0010_0000, 32'd0, PC0, 1'b0, 32'h1003, 1'b0);
  endtask

  task automatic testIllegal();
    runOne("R9 op0 illegal",    24'h7F_F010, 32'd0, 32'd0, PC0, 1'b0, 32'h1003, 1'b1);
    runOne("R9 n0 illegal",     {8'h10, 4'h0, 4'h0, 2'd0, 2'd0, 4'h6}, 32'd0, 32'd0, PC0, 1'b0, 32'h1003, 1'b1);
    runOne("R9 n3 m1 illegal",  encImm(2'd3, 2'd1, 4'd0, 8'h10), 32'd0, 32'd0, PC0, 1'b0, 32'h1003, 1'b1);
  endtask

  task automatic testHold();
    runOne("R10 setup",         encZero(2'd0, 12'h040), 32'd0, 32'd0, PC0, 1'b1, 32'h1044, 1'b0);
    opS = 32'd9; insn = 24'h0;
    @(negedge clk);
    @(negedge clk);
    testsRun++;
    if (outValid !== 1'b0 || taken !== 1'b1 || nextPc !== 32'h1044 || illegal !== 1'b0) begin
      testsFailed++;
      $display("FAIL R10: got v=%0b taken=%0b next=%h ill=%0b, expected v=0 taken=1 next=00001044 ill=0",
               outValid, taken, nextPc, illegal);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroCompare();
    testSignedTable();
    testUnsignedTable();
    testOffsets();
    testRegCompare();
    testMasks();
    testBitReg();
    testBitImm();
    testIllegal();
    testHold();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule